// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM with 32-bit words. It has a registered read path of two stages: the address enters the first stage on one rising edge, and the word is driven on the following edge. Two active-low address strobes can start an access. The processor strobe always performs a read and is gated by the main chip enable. The controller strobe samples the write enables on the same edge and can therefore start either a read or a write. Once a cycle has started, later edges with neither strobe continue it. Those edges step a four-word burst when the advance input is low, hold the address when it is high, and pick read or write from the write enables sampled on that edge.

The data bus is split into a write-data input, a read-data output and a drive qualifier. `drive_o` high means the device owns the bus, and `drive_o` low stands for high impedance. A sleep input switches the bus off at once, makes clock edges do nothing, and keeps the array contents.

Top module: `sram_pipe_burst`

## Requirements
- R1: If an edge E starts or continues a read of address A, `rdata_o` holds the word at A and `drive_o` is high from edge E+1 until edge E+2, provided `oe_ni` is low.
- R2: On an edge with `strobe_cpu_ni` low and `ce_main_ni` low, `addr_i` is loaded and the cycle is a read, whatever the controller strobe and write enables do. If `ce_hi_i` is low or `ce_lo_ni` is high on that edge, the edge is a deselect instead.
- R3: When `ce_main_ni` is high, a low `strobe_cpu_ni` with `strobe_ctl_ni` high is ignored, and any burst in progress continues unchanged.
- R4: On an edge with `strobe_ctl_ni` low and the processor strobe not active, `addr_i` is loaded and the write enables are sampled on that same edge. All three chip enables must be active (`ce_main_ni` low, `ce_hi_i` high, `ce_lo_ni` low); otherwise the edge is a deselect.
- R5: Write mask: `gwe_ni` low writes all four bytes, whatever the byte enables. With `gwe_ni` high and `bwe_ni` low, byte i (bits 8i+7:8i) is written when `bw_ni[i]` is low. If no byte is selected, the cycle is a read.
- R6: On an edge with no strobe, while a cycle is active, `adv_ni` low steps the burst counter and `adv_ni` high holds the current address. The write enables on that edge choose write or read.
- R7: Burst order within the aligned four-word block starting at base address B: when `mode_il_i` is 1, the k-th access uses low bits B[1:0] XOR k; when `mode_il_i` is 0, it uses (B[1:0]+k) mod 4. The upper address bits do not change.
- R8: After an edge that performs a write, `drive_o` is low until the next edge, whatever `oe_ni` is.
- R9: `oe_ni` high forces `drive_o` low at once, with no clock edge needed.
- R10: A deselect at edge E leaves the output of the previous read visible until edge E+1, and `drive_o` is low after E+1.
- R11: `sleep_i` high forces `drive_o` low at once. Edges that occur while it is high write nothing and end any burst. Array contents are kept.
- R12: After reset, `drive_o` is low and no cycle is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| wdata_i | input | 32 | Write data, sampled on write edges |
| strobe_cpu_ni | input | 1 | Processor address strobe, active low |
| strobe_ctl_ni | input | 1 | Controller address strobe, active low |
| ce_main_ni | input | 1 | Main chip enable, active low |
| ce_hi_i | input | 1 | Chip enable, active high |
| ce_lo_ni | input | 1 | Chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gwe_ni | input | 1 | Global write enable, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | 4 | Per-byte enables, active low, bit i selects byte i |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| mode_il_i | input | 1 | Burst order: 1 XOR order, 0 wrapping linear order |
| sleep_i | input | 1 | Power-down, active high |
| rdata_o | output | 32 | Registered read data |
| drive_o | output | 1 | Bus drive qualifier (low means high impedance) |

## Verification
A fault in the strobe decode shows up one edge after the bad edge: `drive_o` is high or low when it should not be, or a word from the wrong address appears. A write landing in the wrong lane stays hidden until that location is read back, two edges after the read strobe. A burst counter that is wrong, or uses the wrong order, shows a word out of sequence from the second beat onward. A stale pipeline stage after a deselect or sleep leaves `drive_o` high one edge too long.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          strobe_cpu_ni,
  input  logic          strobe_ctl_ni,
  input  logic          ce_main_ni,
  input  logic          ce_hi_i,
  input  logic          ce_lo_ni,
  input  logic          gwe_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bw_ni,
  input  logic          sleep_i,
  input  logic          burst_act_i,
  output logic          load_o,
  output sram_op_e      op_o,
  output logic [NB-1:0] wmask_o
);
  logic [NB-1:0] mask;
  logic          sel;

  always_comb begin
    mask    = !gwe_ni ? '1 : (!bwe_ni ? ~bw_ni : '0);
    sel     = !ce_main_ni && ce_hi_i && !ce_lo_ni;
    load_o  = 1'b0;
    op_o    = OP_IDLE;
    wmask_o = '0;
    if (sleep_i) begin
      load_o = 1'b0;
    end else if (!strobe_cpu_ni && !ce_main_ni) begin
      // processor strobe: read only, write enables ignored
      load_o = 1'b1;
      op_o   = sel ? OP_READ : OP_IDLE;
    end else if (!strobe_ctl_ni) begin
      load_o = 1'b1;
      if (sel) begin
        op_o    = (|mask) ? OP_WRITE : OP_READ;
        wmask_o = mask;
      end
    end else if (burst_act_i) begin
      op_o    = (|mask) ? OP_WRITE : OP_READ;
      wmask_o = mask;
    end
  end
endmodule

// File: rtl/sram_burst_gen.sv
module sram_burst_gen #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              mode_il_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, offs;

  always_comb begin
    base_d = load_i ? addr_i : base_q;
    cnt_d  = load_i ? '0 : (step_i ? cnt_q + 1'b1 : cnt_q);
    offs   = mode_il_i ? (base_d[CNT_W-1:0] ^ cnt_d) : (base_d[CNT_W-1:0] + cnt_d);
    addr_o = {base_d[ADDR_W-1:CNT_W], offs};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
  parameter int ADDR_W = 8,
  parameter int NB     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [NB-1:0]     wmask_i,
  input  logic [NB*8-1:0]   wdata_i,
  output logic [NB*8-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = NB * 8;

  logic [DW-1:0]     mem [DEPTH];
  logic [DW-1:0]     bitmask;
  logic [ADDR_W-1:0] raddr_q;
  logic [DW-1:0]     dout_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign bitmask[g*8 +: 8] = {8{wmask_i[g]}};
  end

  always_ff @(posedge clk_i) begin
    if (|wmask_i) mem[addr_i] <= (mem[addr_i] & ~bitmask) | (wdata_i & bitmask);
  end

  // stage 1 address, stage 2 data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raddr_q <= '0;
      dout_q  <= '0;
    end else begin
      if (rd_i) raddr_q <= addr_i;
      dout_q <= mem[raddr_q];
    end
  end

  assign rdata_o = dout_q;
endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              strobe_cpu_ni,
  input  logic              strobe_ctl_ni,
  input  logic              ce_main_ni,
  input  logic              ce_hi_i,
  input  logic              ce_lo_ni,
  input  logic              adv_ni,
  input  logic              gwe_ni,
  input  logic              bwe_ni,
  input  logic [3:0]        bw_ni,
  input  logic              oe_ni,
  input  logic              mode_il_i,
  input  logic              sleep_i,
  output logic [31:0]       rdata_o,
  output logic              drive_o
);
  localparam int NB = 4;

  sram_op_e          dec_op;
  logic              dec_load;
  logic [NB-1:0]     dec_mask;
  logic [ADDR_W-1:0] cur_addr;
  logic              act_q, rd_q, wr_q, drv_q, step;

  sram_cmd_decode #(.NB(NB)) u_dec (
    .strobe_cpu_ni(strobe_cpu_ni), .strobe_ctl_ni(strobe_ctl_ni),
    .ce_main_ni(ce_main_ni), .ce_hi_i(ce_hi_i), .ce_lo_ni(ce_lo_ni),
    .gwe_ni(gwe_ni), .bwe_ni(bwe_ni), .bw_ni(bw_ni),
    .sleep_i(sleep_i), .burst_act_i(act_q),
    .load_o(dec_load), .op_o(dec_op), .wmask_o(dec_mask)
  );

  assign step = !dec_load && act_q && !adv_ni && !sleep_i;

  sram_burst_gen #(.ADDR_W(ADDR_W), .CNT_W(2)) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(dec_load), .step_i(step),
    .mode_il_i(mode_il_i), .addr_i(addr_i), .addr_o(cur_addr)
  );

  sram_bank #(.ADDR_W(ADDR_W), .NB(NB)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(cur_addr),
    .rd_i(dec_op == OP_READ), .wmask_i(dec_mask), .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      act_q <= dec_op != OP_IDLE;
      rd_q  <= dec_op == OP_READ;
      wr_q  <= dec_op == OP_WRITE;
      drv_q <= rd_q;
    end
  end

  assign drive_o = drv_q && !wr_q && !oe_ni && !sleep_i;

  a_r1_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_op == OP_READ) |=> ##1 drv_q);
  a_r2_cpu_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !strobe_cpu_ni && !ce_main_ni) |-> (dec_mask == '0));
  a_r3_cpu_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !strobe_cpu_ni && ce_main_ni && strobe_ctl_ni) |-> !dec_load);
  a_r8_write_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_op == OP_WRITE) |=> !drive_o);
  a_r10_desel_one_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_op == OP_IDLE) |=> ##1 !drive_o);
  a_r11_sleep_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !drive_o);
endmodule

// File: tb/sram_pipe_burst_bench.sv
module sram_pipe_burst_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        scpu_n = 1'b1, sctl_n = 1'b1, cem_n = 1'b0, ceh = 1'b1, cel_n = 1'b0;
  logic        adv_n = 1'b1, gwe_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, mode_il = 1'b1, sleep = 1'b0;
  logic [3:0]  bw_n = 4'hF;
  logic [31:0] rdata;
  logic        drive;

  logic [31:0] ref_mem [256];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_pipe_burst #(.ADDR_W(8)) u_sram_pipe_burst (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .strobe_cpu_ni(scpu_n), .strobe_ctl_ni(sctl_n), .ce_main_ni(cem_n),
    .ce_hi_i(ceh), .ce_lo_ni(cel_n), .adv_ni(adv_n), .gwe_ni(gwe_n),
    .bwe_ni(bwe_n), .bw_ni(bw_n), .oe_ni(oe_n), .mode_il_i(mode_il),
    .sleep_i(sleep), .rdata_o(rdata), .drive_o(drive)
  );

  typedef struct packed { logic [7:0] a; logic [31:0] d; } vec_t;
  localparam vec_t VEC [6] = '{
    '{8'h00, 32'h0123_4567}, '{8'h01, 32'h89AB_CDEF}, '{8'h7F, 32'hFFFF_0000},
    '{8'h80, 32'h0000_FFFF}, '{8'hC3, 32'h5A5A_A5A5}, '{8'hFF, 32'hDEAD_BEEF}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    scpu_n = 1; sctl_n = 1; cem_n = 0; ceh = 1; cel_n = 0;
    adv_n = 1; gwe_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; sleep = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_ctl(logic [7:0] a, logic [31:0] d, logic g, logic b, logic [3:0] m);
    idle(); sctl_n = 0; addr = a; wdata = d; gwe_n = g; bwe_n = b; bw_n = m;
    step();
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !m[i])) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
    idle();
  endtask

  task automatic rd_cpu(logic [7:0] a);
    idle(); scpu_n = 0; addr = a;
    step();
    idle();
    step();
  endtask

  task automatic burst_rd(logic [7:0] base, logic il, string tag);
    mode_il = il;
    idle(); scpu_n = 0; addr = base;
    step();
    idle(); adv_n = 0;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] lo;
      step();
      lo = il ? (base[1:0] ^ 2'(k)) : (base[1:0] + 2'(k));
      chk(tag, rdata, ref_mem[{base[7:2], lo}]);
      chk(tag, {31'd0, drive}, 32'd1);
    end
    idle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R12 drive after reset", {31'd0, drive}, 32'd0);
    rst_ni = 1;
    step();
    chk("R12 idle after reset", {31'd0, drive}, 32'd0);

    // table walk: controller-strobe write, processor-strobe read (R4, R1)
    for (int i = 0; i < 6; i++) begin
      wr_ctl(VEC[i].a, VEC[i].d, 1'b0, 1'b1, 4'hF);
      rd_cpu(VEC[i].a);
      chk("R1 R4 table read data", rdata, VEC[i].d);
      chk("R1 table drive", {31'd0, drive}, 32'd1);
    end

    // R1 latency from deselected state
    idle(); sctl_n = 0; cel_n = 1; step(); idle(); step();
    chk("R4 deselect by chip enable", {31'd0, drive}, 32'd0);
    idle(); scpu_n = 0; addr = 8'h01; step(); idle();
    chk("R1 not yet driven after address edge", {31'd0, drive}, 32'd0);
    step();
    chk("R1 driven after next edge", {31'd0, drive}, 32'd1);
    chk("R1 data after next edge", rdata, VEC[1].d);

    // burst order (R6, R7)
    for (int k = 0; k < 4; k++) wr_ctl(8'h40 + 8'(k), 32'h4000_0000 + 32'(k * 17), 1'b0, 1'b1, 4'hF);
    burst_rd(8'h41, 1'b1, "R7 xor burst read");
    burst_rd(8'h41, 1'b0, "R7 linear burst read");
    mode_il = 1'b1;

    // R6 burst write linear from 0x52, hold with adv high
    mode_il = 1'b0;
    idle(); sctl_n = 0; addr = 8'h52; gwe_n = 0; wdata = 32'hB000_0000; step();
    for (int k = 1; k < 4; k++) begin
      idle(); adv_n = 0; gwe_n = 0; wdata = 32'hB000_0000 + 32'(k); step();
    end
    ref_mem[8'h52] = 32'hB000_0000; ref_mem[8'h53] = 32'hB000_0001;
    ref_mem[8'h50] = 32'hB000_0002; ref_mem[8'h51] = 32'hB000_0003;
    idle(); step(); step();
    chk("R6 hold with adv high shows last address", rdata, ref_mem[8'h51]);
    mode_il = 1'b1;
    for (int k = 0; k < 4; k++) begin
      rd_cpu(8'h50 + 8'(k));
      chk("R6 burst write readback", rdata, ref_mem[8'h50 + 8'(k)]);
    end

    // R5 byte masks
    wr_ctl(8'h60, 32'h1122_3344, 1'b0, 1'b1, 4'hF);
    wr_ctl(8'h60, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010);
    rd_cpu(8'h60);
    chk("R5 byte lanes 0 and 2", rdata, 32'h11BB_33DD);
    wr_ctl(8'h61, 32'h0102_0304, 1'b0, 1'b0, 4'hF);
    rd_cpu(8'h61);
    chk("R5 global write overrides byte enables", rdata, 32'h0102_0304);
    idle(); sctl_n = 0; addr = 8'h60; bwe_n = 0; wdata = 32'h0; step(); idle(); step();
    chk("R5 no byte selected is read", rdata, 32'h11BB_33DD);
    chk("R5 no byte selected drives", {31'd0, drive}, 32'd1);

    // R2 processor strobe wins, write enables ignored
    idle(); scpu_n = 0; sctl_n = 0; gwe_n = 0; addr = 8'h60; wdata = 32'hDEAD_0000;
    step(); idle(); step();
    chk("R2 processor strobe reads", rdata, 32'h11BB_33DD);
    rd_cpu(8'h60);
    chk("R2 no write on processor edge", rdata, 32'h11BB_33DD);

    // R2 deselect via ce_hi and R10 timing
    rd_cpu(8'h40);
    idle(); scpu_n = 0; ceh = 0; step(); idle();
    chk("R10 previous read still visible", {31'd0, drive}, 32'd1);
    step();
    chk("R2 R10 deselect turns off after one stage", {31'd0, drive}, 32'd0);

    // R3 blocked processor strobe
    rd_cpu(8'h40);
    idle(); scpu_n = 0; cem_n = 1; addr = 8'h60; step(); idle(); step();
    chk("R3 burst continues data", rdata, ref_mem[8'h40]);
    chk("R3 burst continues drive", {31'd0, drive}, 32'd1);

    // R8 write edge disables output
    rd_cpu(8'h40);
    idle(); sctl_n = 0; gwe_n = 0; oe_n = 0; addr = 8'h70; wdata = 32'h7070_7070; step();
    ref_mem[8'h70] = 32'h7070_7070;
    chk("R8 output off after write edge", {31'd0, drive}, 32'd0);
    idle();

    // R9 asynchronous output enable
    rd_cpu(8'h40);
    oe_n = 1; #1;
    chk("R9 oe high disables", {31'd0, drive}, 32'd0);
    oe_n = 0; #1;
    chk("R9 oe low re-enables", {31'd0, drive}, 32'd1);

    // R11 sleep
    sleep = 1; #1;
    chk("R11 sleep disables at once", {31'd0, drive}, 32'd0);
    sctl_n = 0; gwe_n = 0; addr = 8'h40; wdata = 32'hBAD0_BAD0; step();
    sctl_n = 1; gwe_n = 1; sleep = 0; step();
    chk("R11 burst ended by sleep", {31'd0, drive}, 32'd0);
    rd_cpu(8'h40);
    chk("R11 contents kept", rdata, ref_mem[8'h40]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule